// File: doc/BRIEF.md
# Conferencing Time-Slot Interchange

This block is the core of a time-division voice switch. A slot sequencer steps through 192 time slots in a fixed order and returns to slot 0, so that one pass over all slots makes one frame. At line rate a frame lasts 125 µs, which means every slot is served 8,000 times per second. In its own slot, each line's 8-bit PCM sample is stored in a sample memory at the address that equals the slot number. Addresses 192 to 255 of the same memory form a tone area. A tone source fills this area through its own port, and any slot can connect to a tone location in the same way it connects to a voice slot.

Each slot owns two connection entries, A and B, which are sample-memory addresses, and a 2-bit pad code. During its slot the block reads the sample addressed by A and the sample addressed by B, and sends out the louder of the two. This is how a three-party call gets its output. In a two-party call A and B hold the same address, so the choice has no effect. The chosen sample is then attenuated by the slot's pad code. A processor connects or disconnects a slot only by writing these tables. Its writes go into a shadow copy, and the whole copy takes effect at the next frame boundary. After that the switch runs without further processor action.

The sequencer is a four-state machine that visits each state once per slot. `ST_FETCH_A` reads the A sample and moves to `ST_FETCH_B`. `ST_FETCH_B` holds the A sample and reads the B sample, then moves to `ST_EMIT`. `ST_EMIT` selects and pads the sample and registers the result, then moves to `ST_STORE`. `ST_STORE` presents the result, writes the incoming line sample and moves to `ST_FETCH_A` of the next slot. When it leaves slot 191 it wraps to slot 0 and loads the shadow tables into the active tables.

Top module: `tsi_conf_switch`

## Requirements
- R1: A slot lasts four clocks, visited in the order fetch A, fetch B, emit, store. `slot_idx` counts 0 to 191 and wraps to 0, and changes only when the store clock ends. `pcm_take` is high in the store clock and low in the other three.
- R2: `pcm_in` is taken at the end of the store clock of slot s and written to sample address s. A later slot that reads address s gets this value. Both reads of a slot happen before its own store, so a slot that reads its own address receives the sample of the previous frame.
- R3: Sample addresses 192 to 255 can be written only through the tone port, where `tone_idx` n writes address 192+n. Line samples never land in that area.
- R4: The output of slot s is taken from the sample at `A[s]` or at `B[s]`. When both entries hold the same address, the output is that sample after padding.
- R5: Samples are sign-magnitude, with bit 7 as the sign and bits 6:0 as the magnitude. The B sample is chosen only when its magnitude is strictly larger than the A magnitude. On a tie the A sample is chosen.
- R6: A pad code p from 0 to 3 shifts the chosen magnitude right by p bits and keeps the sign bit unchanged.
- R7: `cfg_tbl` selects what a processor write changes: 0 writes the A entry, 1 writes the B entry, 2 writes the pad code taken from `cfg_wdata[1:0]`, and 3 is ignored. A write with `cfg_slot` of 192 or more is also ignored.
- R8: A processor write takes effect from slot 0 of the next frame. The current frame keeps the old tables. A write made in the final store clock of a frame still takes effect in the frame that follows.
- R9: The result for slot s is on `pcm_out` with `out_valid` high during the store clock of slot s. `out_valid` is low in all other clocks, and `pcm_out` keeps its last value until the next result.
- R10: After reset the block is in fetch A of slot 0. Every connection entry holds address 192, every pad code is 0, and every sample location is 0. `pcm_out` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pcm_in | input | 8 | Line sample for the current slot, taken in its store clock |
| pcm_take | output | 1 | High in the store clock of the current slot |
| slot_idx | output | 8 | Current slot number |
| tone_we | input | 1 | Tone-area write enable |
| tone_idx | input | 6 | Tone location; writes sample address 192+tone_idx |
| tone_data | input | 8 | Tone sample value |
| cfg_we | input | 1 | Processor table write enable |
| cfg_tbl | input | 2 | Table select: 0 A, 1 B, 2 pad, 3 none |
| cfg_slot | input | 8 | Slot whose entry is written |
| cfg_wdata | input | 8 | Sample address, or pad code in bits 1:0 |
| pcm_out | output | 8 | Switched, padded output sample |
| out_valid | output | 1 | `pcm_out` holds the current slot's result |

## Verification
Two functions can fall in the same clock: a processor table write, and the copy of the shadow tables into the active tables in the last store clock of the frame. The bench forces this collision by placing a directed write exactly in the store clock of slot 191. It judges the result from the output of the written slot in the next frame, where the new value must already be in use. The line-sample store and a tone-area write also fall in the same store clock. Their effect is judged later, through slots that are connected to the affected addresses.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;

    // Per-slot sequencer states, visited once each per slot.
    typedef enum logic [1:0] {
        ST_FETCH_A = 2'd0,
        ST_FETCH_B = 2'd1,
        ST_EMIT    = 2'd2,
        ST_STORE   = 2'd3
    } slot_state_e;

    // Processor table selector. The encoding is visible at the top-level ports.
    typedef enum logic [1:0] {
        TBL_A    = 2'd0,
        TBL_B    = 2'd1,
        TBL_PAD  = 2'd2,
        TBL_NONE = 2'd3
    } cfg_tbl_e;

endpackage

// File: rtl/tsi_slot_seq.sv
`timescale 1ns/1ps
module tsi_slot_seq
    import tsi_pkg::*;
#(
    parameter int SLOTS  = 192,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              rd_sel_b_o,
    output logic              latch_a_o,
    output logic              emit_o,
    output logic              store_o,
    output logic              frame_end_o
);

    slot_state_e       st_q, st_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              last_slot;

    assign last_slot = (32'(slot_q) == SLOTS - 1);

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        slot_d = slot_q;
        unique case (st_q)
            ST_FETCH_A: st_d = ST_FETCH_B;
            ST_FETCH_B: st_d = ST_EMIT;
            ST_EMIT:    st_d = ST_STORE;
            ST_STORE: begin
                st_d   = ST_FETCH_A;
                slot_d = last_slot ? '0 : slot_q + 1'b1;
            end
            default:    st_d = ST_FETCH_A;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_FETCH_A;
            slot_q <= '0;
        end else begin
            st_q   <= st_d;
            slot_q <= slot_d;
        end
    end

    // Outputs
    always_comb begin
        slot_o      = slot_q;
        rd_sel_b_o  = (st_q == ST_FETCH_B);
        latch_a_o   = (st_q == ST_FETCH_B);
        emit_o      = (st_q == ST_EMIT);
        store_o     = (st_q == ST_STORE);
        frame_end_o = (st_q == ST_STORE) && last_slot;
    end

    // R1
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH_A) |=> (st_q == ST_FETCH_B));

    // R1
    emit_then_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMIT) |=> (st_q == ST_STORE));

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STORE && last_slot) |=> (slot_q == '0));

    // R1
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_STORE) |=> $stable(slot_q));

endmodule

// File: rtl/tsi_conn_tables.sv
`timescale 1ns/1ps
module tsi_conn_tables
    import tsi_pkg::*;
#(
    parameter int SLOTS     = 192,
    parameter int SLOT_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int PAD_W     = 2,
    parameter int IDLE_ADDR = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_tbl,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              swap_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output logic [ADDR_W-1:0] rd_a_o,
    output logic [ADDR_W-1:0] rd_b_o,
    output logic [PAD_W-1:0]  rd_pad_o
);

    localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(IDLE_ADDR);

    logic              wr_ok;
    logic [ADDR_W-1:0] act_a [SLOTS];
    logic [ADDR_W-1:0] act_b [SLOTS];
    logic [PAD_W-1:0]  act_p [SLOTS];

    assign wr_ok = cfg_we && (32'(cfg_slot) < SLOTS) && (cfg_tbl != TBL_NONE);

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        logic              hit_a, hit_b, hit_p;
        logic [ADDR_W-1:0] sh_a_q, sh_b_q, ac_a_q, ac_b_q, nx_a, nx_b;
        logic [PAD_W-1:0]  sh_p_q, ac_p_q, nx_p;

        assign hit_a = wr_ok && (cfg_tbl == TBL_A)   && (32'(cfg_slot) == gi);
        assign hit_b = wr_ok && (cfg_tbl == TBL_B)   && (32'(cfg_slot) == gi);
        assign hit_p = wr_ok && (cfg_tbl == TBL_PAD) && (32'(cfg_slot) == gi);

        // The shadow's next value includes a write in the same clock, so a
        // write in the swap clock still reaches the next frame.
        assign nx_a = hit_a ? cfg_wdata : sh_a_q;
        assign nx_b = hit_b ? cfg_wdata : sh_b_q;
        assign nx_p = hit_p ? cfg_wdata[PAD_W-1:0] : sh_p_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_a_q <= RST_ADDR;
                sh_b_q <= RST_ADDR;
                sh_p_q <= '0;
                ac_a_q <= RST_ADDR;
                ac_b_q <= RST_ADDR;
                ac_p_q <= '0;
            end else begin
                sh_a_q <= nx_a;
                sh_b_q <= nx_b;
                sh_p_q <= nx_p;
                if (swap_i) begin
                    ac_a_q <= nx_a;
                    ac_b_q <= nx_b;
                    ac_p_q <= nx_p;
                end
            end
        end

        assign act_a[gi] = ac_a_q;
        assign act_b[gi] = ac_b_q;
        assign act_p[gi] = ac_p_q;
    end

    assign rd_a_o   = act_a[rd_slot_i];
    assign rd_b_o   = act_b[rd_slot_i];
    assign rd_pad_o = act_p[rd_slot_i];

    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> (rd_slot_i != $past(rd_slot_i)) ||
                    (rd_a_o == $past(rd_a_o) && rd_b_o == $past(rd_b_o) &&
                     rd_pad_o == $past(rd_pad_o)));

endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
    parameter int SLOTS  = 192,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int SAMP_W = 8,
    parameter int TONE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vwe_i,
    input  logic [ADDR_W-1:0] vaddr_i,
    input  logic [SAMP_W-1:0] vdata_i,
    input  logic              twe_i,
    input  logic [TONE_W-1:0] tidx_i,
    input  logic [SAMP_W-1:0] tdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [SAMP_W-1:0] rdata_o
);

    logic [SAMP_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] taddr;

    assign taddr = ADDR_W'(SLOTS) + ADDR_W'(tidx_i);

    // Registered read. The voice area and the tone area are disjoint, so the
    // two write ports never target the same location.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata_o <= '0;
        end else begin
            rdata_o <= mem_q[raddr_i];
            if (vwe_i) mem_q[vaddr_i] <= vdata_i;
            if (twe_i) mem_q[taddr]   <= tdata_i;
        end
    end

    // R3
    voice_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vwe_i |-> (32'(vaddr_i) < SLOTS));

    // R2
    write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vwe_i && raddr_i == vaddr_i) |=> (rdata_o == $past(mem_q[raddr_i])));

endmodule

// File: rtl/tsi_select_pad.sv
`timescale 1ns/1ps
module tsi_select_pad #(
    parameter int SAMP_W = 8,
    parameter int PAD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_a_i,
    input  logic              emit_i,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [PAD_W-1:0]  pad_i,
    output logic [SAMP_W-1:0] out_o
);

    localparam int MAG_W = SAMP_W - 1;

    logic [SAMP_W-1:0] a_q, pick;
    logic [MAG_W-1:0]  mag_a, mag_b, shifted;
    logic              take_b;

    assign mag_a   = a_q[MAG_W-1:0];
    assign mag_b   = samp_i[MAG_W-1:0];
    assign take_b  = (mag_b > mag_a);
    assign pick    = take_b ? samp_i : a_q;
    assign shifted = pick[MAG_W-1:0] >> pad_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            out_o <= '0;
        end else begin
            if (latch_a_i) a_q <= samp_i;
            if (emit_i)    out_o <= {pick[SAMP_W-1], shifted};
        end
    end

    // R5
    louder_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && (mag_b > mag_a)) |=> (out_o[SAMP_W-1] == $past(samp_i[SAMP_W-1])));

    // R5
    tie_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && (mag_b == mag_a)) |=> (out_o[SAMP_W-1] == $past(a_q[SAMP_W-1])));

    // R6
    pad_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_i |=> (out_o[MAG_W-1:0] <= $past((mag_b > mag_a) ? mag_b : mag_a)));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_i |=> $stable(out_o));

endmodule

// File: rtl/tsi_conf_switch.sv
`timescale 1ns/1ps
module tsi_conf_switch #(
    parameter int SLOTS  = 192,
    parameter int TONES  = 64,
    parameter int SAMP_W = 8,
    parameter int PAD_W  = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int DEPTH  = SLOTS + TONES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int TONE_W = $clog2(TONES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAMP_W-1:0] pcm_in,
    output logic              pcm_take,
    output logic [SLOT_W-1:0] slot_idx,
    input  logic              tone_we,
    input  logic [TONE_W-1:0] tone_idx,
    input  logic [SAMP_W-1:0] tone_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_tbl,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [SAMP_W-1:0] pcm_out,
    output logic              out_valid
);

    logic              rd_sel_b, latch_a, emit, store, frame_end;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] conn_a, conn_b, raddr;
    logic [PAD_W-1:0]  pad;
    logic [SAMP_W-1:0] rd_samp;
    logic              valid_q;

    tsi_slot_seq #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_o      (slot),
        .rd_sel_b_o  (rd_sel_b),
        .latch_a_o   (latch_a),
        .emit_o      (emit),
        .store_o     (store),
        .frame_end_o (frame_end)
    );

    tsi_conn_tables #(
        .SLOTS     (SLOTS),
        .SLOT_W    (SLOT_W),
        .ADDR_W    (ADDR_W),
        .PAD_W     (PAD_W),
        .IDLE_ADDR (SLOTS)
    ) u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_tbl   (cfg_tbl),
        .cfg_slot  (cfg_slot),
        .cfg_wdata (cfg_wdata),
        .swap_i    (frame_end),
        .rd_slot_i (slot),
        .rd_a_o    (conn_a),
        .rd_b_o    (conn_b),
        .rd_pad_o  (pad)
    );

    assign raddr = rd_sel_b ? conn_b : conn_a;

    tsi_data_mem #(
        .SLOTS  (SLOTS),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .SAMP_W (SAMP_W),
        .TONE_W (TONE_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .vwe_i   (store),
        .vaddr_i (ADDR_W'(slot)),
        .vdata_i (pcm_in),
        .twe_i   (tone_we),
        .tidx_i  (tone_idx),
        .tdata_i (tone_data),
        .raddr_i (raddr),
        .rdata_o (rd_samp)
    );

    tsi_select_pad #(
        .SAMP_W (SAMP_W),
        .PAD_W  (PAD_W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_a_i (latch_a),
        .emit_i    (emit),
        .samp_i    (rd_samp),
        .pad_i     (pad),
        .out_o     (pcm_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= emit;
    end

    assign out_valid = valid_q;
    assign pcm_take  = store;
    assign slot_idx  = slot;

    // R9
    valid_in_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pcm_take);

    // R9
    store_has_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> out_valid);

    // R4
    two_party_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && conn_a == conn_b && pad == '0) |=> (pcm_out == $past(rd_samp)));

endmodule

// File: tb/tsi_conf_switch_tb.sv
`timescale 1ns/1ps
module tsi_conf_switch_tb;

    localparam int SLOTS = 192;
    localparam int FRAME = SLOTS * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pcm_in = '0;
    logic       pcm_take;
    logic [7:0] slot_idx;
    logic       tone_we = 1'b0;
    logic [5:0] tone_idx = '0;
    logic [7:0] tone_data = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_tbl = '0;
    logic [7:0] cfg_slot = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] pcm_out;
    logic       out_valid;

    always #2.5 clk = ~clk;

    tsi_conf_switch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pcm_in    (pcm_in),
        .pcm_take  (pcm_take),
        .slot_idx  (slot_idx),
        .tone_we   (tone_we),
        .tone_idx  (tone_idx),
        .tone_data (tone_data),
        .cfg_we    (cfg_we),
        .cfg_tbl   (cfg_tbl),
        .cfg_slot  (cfg_slot),
        .cfg_wdata (cfg_wdata),
        .pcm_out   (pcm_out),
        .out_valid (out_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model of the memories and tables
    logic [7:0] m_dm [256];
    logic [7:0] sh_a [SLOTS];
    logic [7:0] sh_b [SLOTS];
    logic [7:0] ac_a [SLOTS];
    logic [7:0] ac_b [SLOTS];
    logic [1:0] sh_p [SLOTS];
    logic [1:0] ac_p [SLOTS];
    int         ph = 0;
    int         ms = 0;
    logic [7:0] last_out = '0;
    string      tag = "R10";

    logic       d_we = 1'b0;
    logic [1:0] d_tbl = '0;
    logic [7:0] d_slot = '0;
    logic [7:0] d_data = '0;
    bit         pend_t = 0;
    logic [5:0] pt_idx = '0;
    logic [7:0] pt_data = '0;
    bit         rnd_cfg = 0;
    bit         rnd_tone = 0;

    task automatic chk(bit ok, string t, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (slot %0d)", t, act, expv, ms);
        end
    endtask

    // Sign-magnitude pick of the louder sample (ties keep A), then the pad shift
    function automatic logic [7:0] expect_out(int s);
        logic [7:0] a, b, c;
        a = m_dm[ac_a[s]];
        b = m_dm[ac_b[s]];
        c = (b[6:0] > a[6:0]) ? b : a;
        return {c[7], c[6:0] >> ac_p[s]};
    endfunction

    // One clock: check the outputs at the falling edge, then drive the inputs for this clock
    task automatic step();
        logic [7:0] e, v;
        logic [5:0] ti;
        @(negedge clk);
        if (ph == 3) begin
            e = expect_out(ms);
            chk(pcm_take === 1'b1 && out_valid === 1'b1, "R9", {pcm_take, out_valid}, 3);
            chk(slot_idx == 8'(ms), "R1", slot_idx, ms);
            chk(pcm_out === e, tag, pcm_out, e);
            last_out = e;
            v = 8'($urandom);
            pcm_in = v;
            m_dm[ms] = v;
            if (pend_t) begin
                tone_we = 1'b1; tone_idx = pt_idx; tone_data = pt_data;
                m_dm[SLOTS + int'(pt_idx)] = pt_data;
                pend_t = 0;
            end else if (rnd_tone && $urandom_range(3) == 0) begin
                ti = 6'(8 + $urandom_range(55));
                v = 8'($urandom);
                tone_we = 1'b1; tone_idx = ti; tone_data = v;
                m_dm[SLOTS + int'(ti)] = v;
            end else begin
                tone_we = 1'b0;
            end
        end else begin
            chk(out_valid === 1'b0 && pcm_take === 1'b0, "R1", {pcm_take, out_valid}, 0);
            chk(pcm_out === last_out, "R9", pcm_out, last_out);
            tone_we = 1'b0;
        end
        if (!d_we && rnd_cfg && $urandom_range(3) == 0) begin
            d_we = 1'b1;
            d_tbl = 2'($urandom_range(2));
            d_slot = 8'($urandom_range(SLOTS - 1));
            d_data = 8'($urandom);
        end
        cfg_we = d_we; cfg_tbl = d_tbl; cfg_slot = d_slot; cfg_wdata = d_data;
        if (d_we && d_tbl != 2'd3 && int'(d_slot) < SLOTS) begin
            case (d_tbl)
                2'd0:    sh_a[d_slot] = d_data;
                2'd1:    sh_b[d_slot] = d_data;
                default: sh_p[d_slot] = d_data[1:0];
            endcase
        end
        d_we = 1'b0;
        if (ph == 3 && ms == SLOTS - 1) begin
            for (int i = 0; i < SLOTS; i++) begin
                ac_a[i] = sh_a[i]; ac_b[i] = sh_b[i]; ac_p[i] = sh_p[i];
            end
        end
        ph++;
        if (ph == 4) begin
            ph = 0;
            ms = (ms + 1) % SLOTS;
        end
    endtask

    task automatic cfg(int tbl, int slot, int data);
        d_we = 1'b1; d_tbl = 2'(tbl); d_slot = 8'(slot); d_data = 8'(data);
        step();
    endtask

    task automatic tone(int idx, int data);
        pend_t = 1; pt_idx = 6'(idx); pt_data = 8'(data);
        while (pend_t) step();
    endtask

    task automatic frames(int n);
        repeat (n * FRAME) step();
    endtask

    task automatic to_frame_end();
        while (!(ph == 3 && ms == SLOTS - 1)) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) m_dm[i] = '0;
        for (int i = 0; i < SLOTS; i++) begin
            sh_a[i] = 8'(SLOTS); sh_b[i] = 8'(SLOTS); sh_p[i] = '0;
            ac_a[i] = 8'(SLOTS); ac_b[i] = 8'(SLOTS); ac_p[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(pcm_out === 8'h00, "R10", pcm_out, 0);
        chk(out_valid === 1'b0, "R10", out_valid, 0);
        chk(pcm_take === 1'b0, "R10", pcm_take, 0);
        chk(slot_idx === 8'h00, "R10", slot_idx, 0);
        rst_n = 1'b1;
        ph = 1; ms = 0;

        // R10: untouched tables send the tone-area base location, which reads zero
        rnd_tone = 1;
        frames(1);

        // R3: tone area loaded through the tone port, then connected
        tag = "R3";
        tone(1, 8'h45); tone(2, 8'hC5); tone(3, 8'h10); tone(4, 8'hB0); tone(5, 8'h7F);
        cfg(0, 30, 197); cfg(1, 30, 197);
        cfg(0, 31, 193); cfg(1, 31, 193);
        to_frame_end(); step();
        frames(1);

        // R2: line samples reach other slots; a self-connected slot gets the previous frame
        tag = "R2";
        cfg(0, 40, 5);   cfg(1, 40, 5);
        cfg(0, 41, 41);  cfg(1, 41, 41);
        cfg(0, 42, 191); cfg(1, 42, 191);
        cfg(0, 43, 0);   cfg(1, 43, 0);
        to_frame_end(); step();
        frames(2);

        // R5: equal magnitudes keep A; a strictly louder B wins
        tag = "R5";
        cfg(0, 10, 193); cfg(1, 10, 194);
        cfg(0, 11, 194); cfg(1, 11, 193);
        cfg(0, 12, 195); cfg(1, 12, 196);
        cfg(0, 15, 197); cfg(1, 15, 196);
        to_frame_end(); step();
        frames(1);

        // R6: pad codes 3 and 1
        tag = "R6";
        cfg(0, 13, 196); cfg(1, 13, 196); cfg(2, 13, 3);
        cfg(0, 14, 196); cfg(1, 14, 196); cfg(2, 14, 1);
        cfg(0, 16, 197); cfg(1, 16, 197); cfg(2, 16, 2);
        to_frame_end(); step();
        frames(1);

        // R4: random connections, conferences and pads
        tag = "R4";
        rnd_cfg = 1;
        frames(4);
        rnd_cfg = 0;
        frames(1);

        // R7: table select 3 and slots beyond the last one are ignored
        tag = "R7";
        cfg(3, 50, 8'h11);
        cfg(0, 200, 8'h22);
        cfg(2, 255, 3);
        cfg(1, 192, 8'h05);
        frames(2);

        // R8: writes wait for the next frame, including one in the final store clock
        tag = "R8";
        while (!(ph == 0 && ms == 5)) step();
        cfg(0, 3, 8'h05);
        cfg(0, 100, 8'h06); cfg(1, 100, 8'h06);
        to_frame_end();
        cfg(0, 1, 8'hC5);
        frames(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule